// File: doc/BRIEF.md
# Character Overlay Generator

This block draws a text overlay on a television raster. A host controller loads a grid of 6 rows by 20 columns of character codes into a small video RAM, and sets a few registers. Those registers control where the grid sits on the screen, whether glyphs are drawn at single or double size, and which colours each row uses. The block runs on the pixel clock. It counts pixels from each horizontal sync strobe and lines from each vertical sync strobe, works out which cell and which glyph pixel lies under the beam, and drives per-pixel foreground, background and colour-index signals, plus an overlay enable that a downstream video mixer uses.

Colour is chosen per row, not per character. One row can be turned into a bar-graph row, in which the glyph colour changes at a programmable column, for example to show a volume level. The real font is replaced by a computed stand-in glyph table of 96 glyphs. Each glyph cell is 12 pixels by 15 lines, and each glyph line is read as two 6-pixel halves.

Every output is a combinational function of registered state. The output for the pixel that follows a clock edge is valid after that edge.

Top module: `osd_overlay`

## Requirements
- R1: While reset is asserted and after it is released, with no sync strobe yet received, overlay_en, pix_fg and pix_bg are 0 and pix_color is 0. All registers and all video RAM cells reset to 0.
- R2: Let P be the number of clock edges since the edge that sampled hsync_strobe, and L the number of hsync strobes since the one sampled together with vsync_strobe (that line is L=0). overlay_en is 1 exactly when hpos <= P < hpos+240*sx and vpos <= L < vpos+90*sy, where sx and sy are 1 or 2 (see R8). Outside that window all four outputs are 0. hpos is register 0 and vpos is register 1; registers are written with host_vram_sel=0 and the full 7-bit address.
- R3: Inside the window, let u = (P-hpos)/sx and v = (L-vpos)/sy. The cell is column u/12, row v/15; the glyph pixel is x = u mod 12, line y = v mod 15. The half is h = x/6, and the half word is w = (code + 2*y + h) mod 64. pix_fg is bit (5 - x mod 6) of w, so the most significant bit is the leftmost pixel.
- R4: Codes 0 and 96 to 127 are blank. They never raise pix_fg, and show only the background selected by R7.
- R5: Rows 0 to 5 have attribute registers at addresses 8 to 13. Bits [2:0] hold the glyph colour and bits [6:4] the row background colour. When pix_fg is 1, pix_color is the glyph colour of the current row, unless R6 applies.
- R6: Control register 2 bit 4 enables the bar graph. Register 3 [2:0] selects the bar row, register 4 [4:0] the split column, and register 5 holds colour A in [2:0] and colour B in [6:4]. On the bar row a glyph pixel uses colour A when its column is below the split and colour B otherwise.
- R7: Control bit 2 enables the row background and control bit 3 enables the frame background, whose colour is register 6 [2:0]. A pixel inside the window that is not a glyph pixel has pix_bg=1 if either enable is set. Its pix_color is then the row background colour if bit 2 is set, otherwise the frame colour. With neither enable set, pix_bg and pix_color are 0.
- R8: Control bit 0 doubles the horizontal size (sx=2) and bit 1 doubles the vertical size (sy=2). Each glyph pixel is then repeated over 2 pixels or 2 lines, and the cell counters advance only after the repeated span.
- R9: A write with host_vram_sel=1 stores host_wdata[6:0] into cell row*20+col. Writes to addresses 120 to 127 change no cell.
- R10: pix_fg and pix_bg are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_strobe | input | 1 | One-cycle start-of-line strobe |
| vsync_strobe | input | 1 | One-cycle start-of-field strobe, given together with an hsync strobe |
| host_we | input | 1 | Host write strobe |
| host_vram_sel | input | 1 | 1 selects video RAM, 0 selects registers |
| host_addr | input | 7 | Register or cell address |
| host_wdata | input | 8 | Write data |
| pix_fg | output | 1 | Glyph pixel is lit |
| pix_bg | output | 1 | Background is shown at this pixel |
| pix_color | output | 3 | Colour index for the current pixel |
| overlay_en | output | 1 | Beam is inside the character window |

## Verification
Most internal faults show up as a wrong colour or a wrong glyph bit at the ports within one pixel clock. A cell counter that slips by one, for instance, moves every later glyph pixel of that line, and so shows at the first cell boundary after the slip. A fault in the line counter or the size doubling first shows on the line where a glyph row or a replicated line should change, so the bench compares every pixel of whole fields. A video RAM cell corrupted by an alias write stays wrong for the rest of the field and appears whenever the beam passes that cell.

// File: rtl/osd_pkg.sv
package osd_pkg;
  localparam int OSD_COLS    = 20;
  localparam int OSD_ROWS    = 6;
  localparam int OSD_CELL_W  = 12;
  localparam int OSD_CELL_H  = 15;
  localparam int OSD_GLYPHS  = 96;
  localparam int OSD_CODE_W  = 7;
  localparam int OSD_CLR_W   = 3;
  localparam int OSD_POS_W   = 10;
  localparam int OSD_CELLS_N = OSD_COLS * OSD_ROWS;

  typedef struct packed {
    logic [7:0]           hpos;
    logic [7:0]           vpos;
    logic                 hdbl;
    logic                 vdbl;
    logic                 rowbg_en;
    logic                 frame_en;
    logic                 bar_en;
    logic [2:0]           bar_row;
    logic [4:0]           bar_split;
    logic [OSD_CLR_W-1:0] bar_a;
    logic [OSD_CLR_W-1:0] bar_b;
    logic [OSD_CLR_W-1:0] frame_col;
  } osd_cfg_t;
endpackage

// File: rtl/osd_axis_ctr.sv
module osd_axis_ctr #(
  parameter int CELL  = 12,
  parameter int CELLS = 20,
  parameter int POS_W = 10,
  localparam int SUB_W = $clog2(CELL),
  localparam int IDX_W = $clog2(CELLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [7:0]       start_pos,
  input  logic             dbl,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic [SUB_W-1:0] sub
);
  logic [POS_W-1:0] pos_q, pos_d;
  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic             rep_q, rep_d;

  always_comb begin
    pos_d = pos_q;
    act_d = act_q;
    idx_d = idx_q;
    sub_d = sub_q;
    rep_d = rep_q;
    if (restart) begin
      pos_d = '0;
      act_d = (start_pos == 8'd0);
      idx_d = '0;
      sub_d = '0;
      rep_d = 1'b0;
    end else if (step) begin
      if (pos_q != {POS_W{1'b1}}) pos_d = pos_q + 1'b1;
      if (act_q) begin
        if (dbl && !rep_q) begin
          rep_d = 1'b1;
        end else begin
          rep_d = 1'b0;
          if (sub_q == SUB_W'(CELL - 1)) begin
            sub_d = '0;
            if (idx_q == IDX_W'(CELLS - 1)) act_d = 1'b0;
            else                            idx_d = idx_q + 1'b1;
          end else begin
            sub_d = sub_q + 1'b1;
          end
        end
      end else if (pos_d == POS_W'(start_pos)) begin
        act_d = 1'b1;
        idx_d = '0;
        sub_d = '0;
        rep_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      act_q <= 1'b0;
      idx_q <= '0;
      sub_q <= '0;
      rep_q <= 1'b0;
    end else if (restart || step) begin
      pos_q <= pos_d;
      act_q <= act_d;
      idx_q <= idx_d;
      sub_q <= sub_d;
      rep_q <= rep_d;
    end
  end

  assign active = act_q;
  assign idx    = idx_q;
  assign sub    = sub_q;

  AST_ENTRY_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> (idx_q == '0 && sub_q == '0 && !rep_q)); // R2
  AST_CELL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (idx_q < IDX_W'(CELLS) && sub_q < SUB_W'(CELL))); // R3
  AST_SINGLE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !rep_q && !dbl && step && !restart) |=> !rep_q); // R8
endmodule

// File: rtl/osd_glyph_rom.sv
module osd_glyph_rom #(
  parameter int CODE_W = 7,
  parameter int LINE_W = 4,
  parameter int HALF_W = 6,
  parameter int GLYPHS = 96
) (
  input  logic [CODE_W-1:0] code,
  input  logic [LINE_W-1:0] line,
  input  logic              half,
  output logic [HALF_W-1:0] word
);
  logic             blank;
  logic [HALF_W-1:0] sum;

  assign blank = (code == '0) || (code >= CODE_W'(GLYPHS));
  assign sum   = HALF_W'(code) + HALF_W'({line, 1'b0}) + HALF_W'(half);
  assign word  = blank ? '0 : sum;
endmodule

// File: rtl/osd_regs.sv
module osd_regs
  import osd_pkg::*;
#(
  parameter int ROWS   = OSD_ROWS,
  parameter int CELLS  = OSD_CELLS_N,
  parameter int CODE_W = OSD_CODE_W,
  parameter int CLR_W  = OSD_CLR_W,
  localparam int ATTR_BASE = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_vram,
  input  logic [6:0]                  wr_addr,
  input  logic [7:0]                  wr_data,
  input  logic [6:0]                  rd_addr,
  output logic [CODE_W-1:0]           rd_code,
  output osd_cfg_t                    cfg,
  output logic [ROWS-1:0][CLR_W-1:0]  row_fg,
  output logic [ROWS-1:0][CLR_W-1:0]  row_bg
);
  osd_cfg_t                    cfg_q, cfg_d;
  logic [ROWS-1:0][CLR_W-1:0]  fg_q, fg_d, bg_q, bg_d;
  logic [CELLS-1:0][CODE_W-1:0] mem_q;
  logic                        reg_we, vram_we;

  assign reg_we  = wr_en && !wr_vram;
  assign vram_we = wr_en && wr_vram;

  always_comb begin
    cfg_d = cfg_q;
    fg_d  = fg_q;
    bg_d  = bg_q;
    case (wr_addr)
      7'd0: cfg_d.hpos = wr_data;
      7'd1: cfg_d.vpos = wr_data;
      7'd2: begin
        cfg_d.hdbl     = wr_data[0];
        cfg_d.vdbl     = wr_data[1];
        cfg_d.rowbg_en = wr_data[2];
        cfg_d.frame_en = wr_data[3];
        cfg_d.bar_en   = wr_data[4];
      end
      7'd3: cfg_d.bar_row   = wr_data[2:0];
      7'd4: cfg_d.bar_split = wr_data[4:0];
      7'd5: begin
        cfg_d.bar_a = wr_data[CLR_W-1:0];
        cfg_d.bar_b = wr_data[4 +: CLR_W];
      end
      7'd6: cfg_d.frame_col = wr_data[CLR_W-1:0];
      default: begin
        for (int r = 0; r < ROWS; r++) begin
          if (wr_addr == 7'(ATTR_BASE + r)) begin
            fg_d[r] = wr_data[CLR_W-1:0];
            bg_d[r] = wr_data[4 +: CLR_W];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      fg_q  <= '0;
      bg_q  <= '0;
    end else if (reg_we) begin
      cfg_q <= cfg_d;
      fg_q  <= fg_d;
      bg_q  <= bg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (vram_we) begin
      for (int i = 0; i < CELLS; i++) begin
        if (wr_addr == 7'(i)) mem_q[i] <= wr_data[CODE_W-1:0];
      end
    end
  end

  always_comb begin
    rd_code = '0;
    for (int i = 0; i < CELLS; i++) begin
      if (rd_addr == 7'(i)) rd_code = mem_q[i];
    end
  end

  assign cfg    = cfg_q;
  assign row_fg = fg_q;
  assign row_bg = bg_q;

  AST_ALIAS_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_we && wr_addr >= 7'(CELLS)) |=> $stable(mem_q)); // R9
  AST_VRAM_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vram_we |=> $stable(mem_q)); // R9
endmodule

// File: rtl/osd_overlay.sv
module osd_overlay
  import osd_pkg::*;
#(
  parameter int COLS   = OSD_COLS,
  parameter int ROWS   = OSD_ROWS,
  parameter int CELL_W = OSD_CELL_W,
  parameter int CELL_H = OSD_CELL_H,
  parameter int GLYPHS = OSD_GLYPHS,
  localparam int HALF_W = CELL_W / 2,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int XS_W   = $clog2(CELL_W),
  localparam int YS_W   = $clog2(CELL_H),
  localparam int BIT_W  = $clog2(HALF_W)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_strobe,
  input  logic       vsync_strobe,
  input  logic       host_we,
  input  logic       host_vram_sel,
  input  logic [6:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic       pix_fg,
  output logic       pix_bg,
  output logic [2:0] pix_color,
  output logic       overlay_en
);
  osd_cfg_t                       cfg;
  logic [ROWS-1:0][OSD_CLR_W-1:0] row_fg, row_bg;
  logic [OSD_CODE_W-1:0]          code;
  logic [6:0]                     rd_addr;

  logic             h_act, v_act, in_win;
  logic [COL_W-1:0] h_col;
  logic [XS_W-1:0]  h_sub;
  logic [ROW_W-1:0] v_row;
  logic [YS_W-1:0]  v_line;

  logic              half;
  logic [BIT_W-1:0]  bit_k;
  logic [BIT_W-1:0]  bit_sel;
  logic [HALF_W-1:0] word;
  logic              glyph_on;
  logic [2:0]        fg_clr, rfg, rbg;
  logic              bar_hit;

  osd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_we),
    .wr_vram (host_vram_sel),
    .wr_addr (host_addr),
    .wr_data (host_wdata),
    .rd_addr (rd_addr),
    .rd_code (code),
    .cfg     (cfg),
    .row_fg  (row_fg),
    .row_bg  (row_bg)
  );

  osd_axis_ctr #(.CELL(CELL_W), .CELLS(COLS), .POS_W(OSD_POS_W)) u_hctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (hsync_strobe),
    .step      (1'b1),
    .start_pos (cfg.hpos),
    .dbl       (cfg.hdbl),
    .active    (h_act),
    .idx       (h_col),
    .sub       (h_sub)
  );

  osd_axis_ctr #(.CELL(CELL_H), .CELLS(ROWS), .POS_W(OSD_POS_W)) u_vctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (vsync_strobe),
    .step      (hsync_strobe),
    .start_pos (cfg.vpos),
    .dbl       (cfg.vdbl),
    .active    (v_act),
    .idx       (v_row),
    .sub       (v_line)
  );

  assign in_win  = h_act && v_act;
  assign rd_addr = 7'(v_row) * 7'(COLS) + 7'(h_col);

  assign half    = (h_sub >= XS_W'(HALF_W));
  assign bit_k   = half ? BIT_W'(h_sub - XS_W'(HALF_W)) : BIT_W'(h_sub);
  assign bit_sel = BIT_W'(HALF_W - 1) - bit_k;

  osd_glyph_rom #(.CODE_W(OSD_CODE_W), .LINE_W(YS_W), .HALF_W(HALF_W), .GLYPHS(GLYPHS)) u_glyph (
    .code (code),
    .line (v_line),
    .half (half),
    .word (word)
  );

  assign glyph_on = word[bit_sel];

  always_comb begin
    rfg = '0;
    rbg = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (v_row == ROW_W'(r)) begin
        rfg = row_fg[r];
        rbg = row_bg[r];
      end
    end
  end

  assign bar_hit = cfg.bar_en && (3'(v_row) == cfg.bar_row);

  always_comb begin
    if (bar_hit) fg_clr = (5'(h_col) < cfg.bar_split) ? cfg.bar_a : cfg.bar_b;
    else         fg_clr = rfg;
  end

  always_comb begin
    pix_fg     = 1'b0;
    pix_bg     = 1'b0;
    pix_color  = '0;
    overlay_en = in_win;
    if (in_win) begin
      if (glyph_on) begin
        pix_fg    = 1'b1;
        pix_color = fg_clr;
      end else if (cfg.rowbg_en) begin
        pix_bg    = 1'b1;
        pix_color = rbg;
      end else if (cfg.frame_en) begin
        pix_bg    = 1'b1;
        pix_color = cfg.frame_col;
      end
    end
  end

  AST_FG_NEEDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fg |-> overlay_en); // R2
  AST_DARK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_en |-> (pix_color == '0 && !pix_bg)); // R2
  AST_FG_BG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_fg && pix_bg)); // R10
  AST_BLANK_CODE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0 || code >= 7'(GLYPHS)) |-> !pix_fg); // R4
endmodule

// File: tb/osd_overlay_bench.sv
module osd_overlay_bench;
  logic       clk, rst_n;
  logic       hsync_strobe, vsync_strobe;
  logic       host_we, host_vram_sel;
  logic [6:0] host_addr;
  logic [7:0] host_wdata;
  logic       pix_fg, pix_bg, overlay_en;
  logic [2:0] pix_color;

  osd_overlay u_osd_overlay (
    .clk(clk), .rst_n(rst_n),
    .hsync_strobe(hsync_strobe), .vsync_strobe(vsync_strobe),
    .host_we(host_we), .host_vram_sel(host_vram_sel),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .pix_fg(pix_fg), .pix_bg(pix_bg), .pix_color(pix_color),
    .overlay_en(overlay_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, both_cnt = 0;
  bit done = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  // shadow configuration
  int hpos, vpos, hd, vd, rbe, fre, bare, bar_row, split, bar_a, bar_b, frame_col;
  int rowfg[6], rowbg[6];
  int vram_sh[120];
  bit dbl_frame;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [5:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {overlay_en, pix_fg, pix_bg, pix_color};
      tests++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: {ovl,fg,bg,color} got %b expected %b", t, a, e);
      end
      if (pix_fg && pix_bg) both_cnt++;
    end
  end

  task automatic wr(input logic vsel, input int a, input int d);
    host_we = 1'b1; host_vram_sel = vsel;
    host_addr = 7'(a); host_wdata = 8'(d);
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic model(input int L, input int P, output logic [5:0] e, output string tag);
    int hs, vs, ux, uy, col, row, px, ln, idx, code, half, k, w;
    bit fg, bg, blank, onbar;
    int fgc, clr;
    hs = hd ? 2 : 1;
    vs = vd ? 2 : 1;
    if (P < hpos || P >= hpos + 240*hs || L < vpos || L >= vpos + 90*vs) begin
      e = '0; tag = "R2"; return;
    end
    ux = (P - hpos) / hs;  uy = (L - vpos) / vs;
    col = ux / 12;  px = ux % 12;
    row = uy / 15;  ln = uy % 15;
    idx = row*20 + col;
    code = vram_sh[idx];
    blank = (code == 0) || (code >= 96);
    half = px / 6;  k = px % 6;
    w = blank ? 0 : (code + 2*ln + half) % 64;
    fg = w[5-k];
    onbar = bare && (row == bar_row);
    fgc = onbar ? ((col < split) ? bar_a : bar_b) : rowfg[row];
    bg = !fg && (rbe || fre);
    clr = fg ? fgc : (rbe ? rowbg[row] : (fre ? frame_col : 0));
    e = {1'b1, fg, bg, 3'(clr)};
    if (dbl_frame)      tag = "R8";
    else if (idx == 0)  tag = "R9";   // alias write target
    else if (blank)     tag = "R4";
    else if (onbar)     tag = "R6";
    else if (fre && !rbe) tag = "R7";
    else if (fg)        tag = "R3";
    else                tag = "R5";
  endtask

  task automatic push(input int L, input int P);
    logic [5:0] e; string t;
    model(L, P, e, t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic run_frame(input int nlines, input int npix);
    for (int L = 0; L < nlines; L++) begin
      hsync_strobe = 1'b1;
      vsync_strobe = (L == 0);
      @(posedge clk); #1;
      hsync_strobe = 1'b0; vsync_strobe = 1'b0;
      push(L, 0);
      for (int p = 1; p < npix; p++) begin
        @(posedge clk); #1;
        push(L, p);
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic set_ctrl(input int h, input int v, input int rb, input int fr, input int br);
    hd = h; vd = v; rbe = rb; fre = fr; bare = br;
    wr(0, 2, h | (v << 1) | (rb << 2) | (fr << 3) | (br << 4));
  endtask

  initial begin
    rst_n = 1'b0; hsync_strobe = 0; vsync_strobe = 0;
    host_we = 0; host_vram_sel = 0; host_addr = 0; host_wdata = 0;
    hpos = 0; vpos = 0; hd = 0; vd = 0; rbe = 0; fre = 0; bare = 0;
    bar_row = 0; split = 0; bar_a = 0; bar_b = 0; frame_col = 0; dbl_frame = 0;
    foreach (vram_sh[i]) vram_sh[i] = 0;
    foreach (rowfg[i]) begin rowfg[i] = 0; rowbg[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs dark during reset and after release before any strobe
    tests++;
    if ({overlay_en, pix_fg, pix_bg, pix_color} !== 6'b0) begin
      fails++;
      $display("FAIL R1: in reset got %b expected 000000", {overlay_en, pix_fg, pix_bg, pix_color});
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      exp_q.push_back(6'b0); tag_q.push_back("R1");
    end
    @(posedge clk); #1;

    // configuration for the first field
    hpos = 5;  wr(0, 0, hpos);
    vpos = 2;  wr(0, 1, vpos);
    set_ctrl(0, 0, 1, 0, 1);
    bar_row = 2; wr(0, 3, bar_row);
    split = 7;   wr(0, 4, split);
    bar_a = 3; bar_b = 6; wr(0, 5, bar_a | (bar_b << 4));
    frame_col = 5; wr(0, 6, frame_col);
    for (int r = 0; r < 6; r++) begin
      rowfg[r] = (r + 1) % 8;
      rowbg[r] = 7 - r;
      wr(0, 8 + r, rowfg[r] | (rowbg[r] << 4));
    end
    for (int i = 0; i < 120; i++) begin
      vram_sh[i] = (i * 7) % 128;
      wr(1, i, vram_sh[i]);
    end
    // R9: writes above the cell range must not land anywhere
    wr(1, 120, 5);
    wr(1, 127, 9);

    dbl_frame = 0;
    run_frame(95, 250);

    // R7: frame background only, bar off
    set_ctrl(0, 0, 0, 1, 0);
    run_frame(41, 250);

    // R8: doubled size, window at origin
    hpos = 0; wr(0, 0, 0);
    vpos = 0; wr(0, 1, 0);
    set_ctrl(1, 1, 1, 0, 1);
    dbl_frame = 1;
    run_frame(36, 485);

    repeat (3) @(posedge clk);
    // R10: glyph and background never together
    tests++;
    if (both_cnt != 0) begin
      fails++;
      $display("FAIL R10: fg&bg cycles got %0d expected 0", both_cnt);
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule